// File: doc/BRIEF.md
# Page Program Buffer and Self-Timed Write Sequencer

This block sits behind the serial command front end of a small nonvolatile memory. When a page-program command has been decoded, the front end signals the start of the transfer with the target address. It then hands over every complete data byte and finally reports the rising edge of chip select, together with whether that edge fell on a byte boundary. The block gathers the bytes into a one-page buffer. It keeps the page number fixed for the whole transfer, and it advances a six-bit in-page offset that wraps, so later bytes overwrite earlier ones. It also records which offsets were actually loaded.

At the closing chip-select edge the block commits the page only if all of these hold: the edge is byte-aligned, at least one byte was loaded, the external protection verdict allows the write (this verdict already covers the write-enable latch and the protected-block test), and no earlier write is still in progress. A committed write raises busy for a fixed number of clock cycles. In the first page-size cycles of that interval the block walks the offsets in ascending order and drives one array write per loaded byte. It leaves the other bytes of the page alone. A single-cycle completion pulse in the last busy cycle tells the status logic to clear its write-enable latch. A refused write produces neither busy nor the pulse, so the latch keeps its value.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are all 0.
- R2: Every array write of a transfer uses the page bits (address bits 13:6) of the start address. The first data byte goes to the start offset (bits 5:0).
- R3: Each loaded byte advances the offset by one, modulo 64. When more than 64 bytes are loaded, a later byte replaces an earlier one at the same offset, so the array receives the last value loaded at each offset.
- R4: Only offsets loaded during the transfer are written. Writes occur in ascending offset order, with the write for offset k in busy cycle k (counting from 0), one byte per cycle, and mem_we_o is never high outside busy.
- R5: A chip-select rise with cs_aligned_i = 0 starts no busy period, causes no array write and gives no done_o pulse.
- R6: A chip-select rise after zero loaded data bytes starts no busy period and causes no array write.
- R7: A chip-select rise with prot_ok_i = 0 starts no busy period, causes no array write and gives no done_o pulse.
- R8: A committed write raises busy_o at the clock edge that samples cs_rise_i. Busy stays high for exactly WRITE_CYCLES cycles, and done_o is high for exactly one cycle, the last busy cycle.
- R9: While busy_o is high, start, byte and chip-select strobes are ignored. The running write, its length and its data are unchanged, and no new transfer is opened by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-transfer strobe |
| start_addr_i | input | 14 | Byte address given with the start strobe |
| byte_vld_i | input | 1 | One complete data byte is present |
| byte_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select went high |
| cs_aligned_i | input | 1 | The chip-select rise came after a whole number of bytes |
| prot_ok_i | input | 1 | Protection verdict: 1 allows the write |
| busy_o | output | 1 | Self-timed write in progress |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 14 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench loads more than a page starting near the top of a page. A design that did not wrap, or that kept the first value instead of the last, would write the wrong data or leave the page. A transfer of four bytes starting at offset 62 must produce writes at offsets 0, 1, 62 and 63 only, in that order, on the original page. Carrying the offset into the page bits or writing unloaded offsets would break that list. Misaligned, empty and protected closes must leave busy low. A strobe burst during busy must neither extend the interval nor queue a second write, and a design that let either through would show extra writes or a second completion pulse.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 6;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PAGE_W     = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [PAGE_BYTES-1:0] mask_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t data;
    } arr_wr_t;

    function automatic page_t page_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(input addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic addr_t join_addr(input page_t p, input off_t o);
        return {p, o};
    endfunction

endpackage

// File: rtl/pgw_loader.sv
module pgw_loader
    import pgw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  addr_t start_addr_i,
    input  logic  byte_vld_i,
    input  data_t byte_data_i,
    input  logic  close_i,
    input  logic  block_i,
    input  off_t  rd_off_i,
    output logic  open_o,
    output page_t page_o,
    output mask_t mask_o,
    output data_t rd_data_o
);

    logic  open_q;
    page_t page_q;
    off_t  off_q;
    mask_t mask_q;
    logic  take;
    logic [PAGE_BYTES*DATA_W-1:0] lanes;

    assign take = byte_vld_i && open_q && !close_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            page_q <= '0;
            off_q  <= '0;
            mask_q <= '0;
        end else if (close_i) begin
            open_q <= 1'b0;
        end else if (start_i && !block_i) begin
            open_q <= 1'b1;
            page_q <= page_of(start_addr_i);
            off_q  <= off_of(start_addr_i);
            mask_q <= '0;
        end else if (take) begin
            mask_q[off_q] <= 1'b1;
            off_q         <= off_q + 1'b1;
        end
    end

    // one storage lane per in-page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        data_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (take && off_q == off_t'(g)) begin
                q <= byte_data_i;
            end
        end
        assign lanes[g*DATA_W +: DATA_W] = q;
    end

    assign rd_data_o = lanes[{rd_off_i, 3'b000} +: DATA_W];
    assign open_o    = open_q;
    assign page_o    = page_q;
    assign mask_o    = mask_q;

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int WRITE_CYCLES = 100
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    commit_i,
    input  page_t   page_i,
    input  mask_t   mask_i,
    input  data_t   rd_data_i,
    output off_t    rd_off_o,
    output logic    busy_o,
    output logic    done_o,
    output arr_wr_t wr_o
);

    localparam int TW = $clog2(WRITE_CYCLES) + 1;
    localparam logic [TW-1:0] LAST = TW'(WRITE_CYCLES - 1);
    localparam logic [TW-1:0] SCAN_END = TW'(PAGE_BYTES);

    logic          busy_q;
    logic [TW-1:0] tmr_q;
    logic          scanning;
    off_t          cur_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
        end else if (commit_i && !busy_q) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
        end else if (busy_q) begin
            if (tmr_q == LAST) begin
                busy_q <= 1'b0;
                tmr_q  <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign cur_off  = tmr_q[OFF_W-1:0];
    assign scanning = busy_q && (tmr_q < SCAN_END);
    assign rd_off_o = cur_off;
    assign busy_o   = busy_q;
    assign done_o   = busy_q && (tmr_q == LAST);

    always_comb begin
        wr_o.we   = scanning && mask_i[cur_off];
        wr_o.addr = join_addr(page_i, cur_off);
        wr_o.data = rd_data_i;
    end

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pgw_pkg::*;
#(
    parameter int WRITE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              cs_rise_i,
    input  logic              cs_aligned_i,
    input  logic              prot_ok_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    logic    xfer_open;
    page_t   xfer_page;
    mask_t   xfer_mask;
    data_t   rd_data;
    off_t    rd_off;
    logic    busy;
    logic    commit;
    arr_wr_t wr;

    assign commit = cs_rise_i && cs_aligned_i && xfer_open
                    && (|xfer_mask) && prot_ok_i && !busy;

    pgw_loader u_loader (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .byte_vld_i   (byte_vld_i),
        .byte_data_i  (byte_data_i),
        .close_i      (cs_rise_i),
        .block_i      (busy),
        .rd_off_i     (rd_off),
        .open_o       (xfer_open),
        .page_o       (xfer_page),
        .mask_o       (xfer_mask),
        .rd_data_o    (rd_data)
    );

    pgw_sequencer #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .page_i    (xfer_page),
        .mask_i    (xfer_mask),
        .rd_data_i (rd_data),
        .rd_off_o  (rd_off),
        .busy_o    (busy),
        .done_o    (done_o),
        .wr_o      (wr)
    );

    assign busy_o      = busy;
    assign mem_we_o    = wr.we;
    assign mem_addr_o  = wr.addr;
    assign mem_wdata_o = wr.data;

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk
    import pgw_pkg::*;
#(
    parameter int WRITE_CYCLES = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_rise_i,
    input logic              cs_aligned_i,
    input logic              prot_ok_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    localparam int CW = $clog2(WRITE_CYCLES) + 1;
    logic [CW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) busy_len <= '0;
        else                busy_len <= busy_len + 1'b1;
    end

    // R4
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R8
    done_at_length_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_len == CW'(WRITE_CYCLES - 1)));

    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R5
    misaligned_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise_i && !cs_aligned_i && !busy_o) |=> !busy_o);

    // R7
    protected_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise_i && !prot_ok_i && !busy_o) |=> !busy_o);

    // R9
    busy_from_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cs_rise_i));

    // R2
    page_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o) && busy_len != 0)
            |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

endmodule

bind page_write_engine pgw_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_pgw_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_rise_i    (cs_rise_i),
    .cs_aligned_i (cs_aligned_i),
    .prot_ok_i    (prot_ok_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o)
);

// File: tb/tb_page_write_engine.sv
module tb_page_write_engine;

    localparam int WC = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [13:0] start_addr_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        cs_rise_i = 1'b0;
    logic        cs_aligned_i = 1'b0;
    logic        prot_ok_i = 1'b0;
    logic        busy_o, done_o, mem_we_o;
    logic [13:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;

    page_write_engine #(.WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_vld_i(byte_vld_i), .byte_data_i(byte_data_i),
        .cs_rise_i(cs_rise_i), .cs_aligned_i(cs_aligned_i), .prot_ok_i(prot_ok_i),
        .busy_o(busy_o), .done_o(done_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // capture of the array write port
    int       cap_n = 0;
    int       busy_cnt = 0;
    int       done_cnt = 0;
    int       busy_seq_ok = 1;
    logic [13:0] cap_a [256];
    logic [7:0]  cap_d [256];

    // expected page image
    bit          exp_v [64];
    logic [7:0]  exp_d [64];
    logic [7:0]  exp_page;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we_o) begin
                if (cap_n < 256) begin
                    cap_a[cap_n] = mem_addr_o;
                    cap_d[cap_n] = mem_wdata_o;
                end
                // R4: write for offset k must come in busy cycle k
                if (busy_cnt != int'(mem_addr_o[5:0])) busy_seq_ok = 0;
                cap_n++;
            end
            if (busy_o) busy_cnt++;
            if (done_o) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_caps();
        cap_n = 0;
        busy_cnt = 0;
        done_cnt = 0;
        busy_seq_ok = 1;
        for (int i = 0; i < 64; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
        end
    endtask

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'(seed + i * 37);
    endfunction

    // open, load n bytes, and close; returns nothing, expectations filled
    task automatic load_xfer(input logic [13:0] addr, input int n, input int seed);
        int off;
        off = int'(addr[5:0]);
        exp_page = addr[13:6];
        start_i = 1'b1; start_addr_i = addr;
        tick();
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld_i = 1'b1; byte_data_i = dat(seed, i);
            exp_v[off] = 1'b1; exp_d[off] = dat(seed, i);
            off = (off + 1) % 64;
            tick();
        end
        byte_vld_i = 1'b0;
    endtask

    task automatic close_xfer(input bit aligned, input bit prot, input bit exp_busy, input string req);
        cs_rise_i = 1'b1; cs_aligned_i = aligned; prot_ok_i = prot;
        tick();
        cs_rise_i = 1'b0; cs_aligned_i = 1'b0; prot_ok_i = 1'b0;
        chk(busy_o == exp_busy, req, busy_o, exp_busy);
    endtask

    task automatic check_writes(input string req);
        int k;
        int exp_n;
        k = 0;
        exp_n = 0;
        for (int o = 0; o < 64; o++) if (exp_v[o]) exp_n++;
        chk(cap_n == exp_n, {req, " write count"}, cap_n, exp_n);
        for (int o = 0; o < 64; o++) begin
            if (exp_v[o] && k < cap_n) begin
                chk(cap_a[k] == {exp_page, 6'(o)}, {req, " address"}, cap_a[k], {exp_page, 6'(o)});
                chk(cap_d[k] == exp_d[o], {req, " data"}, cap_d[k], exp_d[o]);
                k++;
            end
        end
        chk(busy_seq_ok == 1, "R4 write cycle matches offset", busy_seq_ok, 1);
    endtask

    task automatic wait_idle();
        repeat (WC + 6) tick();
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
        chk(mem_we_o == 1'b0, "R1 we after reset", mem_we_o, 0);
    endtask

    task automatic t_basic();
        clear_caps();
        load_xfer(14'h1234, 5, 3);
        close_xfer(1'b1, 1'b1, 1'b1, "R8 busy after commit");
        wait_idle();
        check_writes("R2 basic");
        chk(busy_cnt == WC, "R8 busy length", busy_cnt, WC);
        chk(done_cnt == 1, "R8 done count", done_cnt, 1);
    endtask

    task automatic t_overflow();
        clear_caps();
        load_xfer(14'h2ABC, 70, 11);
        close_xfer(1'b1, 1'b1, 1'b1, "R3 busy after commit");
        wait_idle();
        check_writes("R3 overflow keeps last 64");
    endtask

    task automatic t_edge_wrap();
        clear_caps();
        load_xfer(14'h07FE, 4, 90);
        close_xfer(1'b1, 1'b1, 1'b1, "R4 busy after commit");
        wait_idle();
        check_writes("R4 masked wrap");
        chk(cap_a[0] == 14'h07C0, "R2 page kept on wrap", cap_a[0], 14'h07C0);
    endtask

    task automatic t_misaligned();
        clear_caps();
        load_xfer(14'h0100, 3, 5);
        close_xfer(1'b0, 1'b1, 1'b0, "R5 no busy when misaligned");
        wait_idle();
        chk(cap_n == 0, "R5 no writes", cap_n, 0);
        chk(done_cnt == 0, "R5 no done", done_cnt, 0);
    endtask

    task automatic t_empty();
        clear_caps();
        load_xfer(14'h0200, 0, 0);
        close_xfer(1'b1, 1'b1, 1'b0, "R6 no busy when empty");
        wait_idle();
        chk(cap_n == 0, "R6 no writes", cap_n, 0);
    endtask

    task automatic t_protected();
        clear_caps();
        load_xfer(14'h3F00, 8, 77);
        close_xfer(1'b1, 1'b0, 1'b0, "R7 no busy when protected");
        wait_idle();
        chk(cap_n == 0, "R7 no writes", cap_n, 0);
        chk(done_cnt == 0, "R7 no done", done_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        clear_caps();
        load_xfer(14'h0AC5, 6, 21);
        close_xfer(1'b1, 1'b1, 1'b1, "R9 busy after commit");
        repeat (3) tick();
        // second transfer attempted while busy; bench expectations unchanged
        start_i = 1'b1; start_addr_i = 14'h0000;
        tick();
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            byte_vld_i = 1'b1; byte_data_i = 8'hEE;
            tick();
        end
        byte_vld_i = 1'b0;
        cs_rise_i = 1'b1; cs_aligned_i = 1'b1; prot_ok_i = 1'b1;
        tick();
        cs_rise_i = 1'b0; cs_aligned_i = 1'b0; prot_ok_i = 1'b0;
        wait_idle();
        check_writes("R9 running write unchanged");
        chk(busy_cnt == WC, "R9 busy not extended", busy_cnt, WC);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);
        // no transfer was opened during busy, so a bare close does nothing
        close_xfer(1'b1, 1'b1, 1'b0, "R9 no transfer opened during busy");
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_overflow();
        t_edge_wrap();
        t_misaligned();
        t_empty();
        t_protected();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule